// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This unit gathers the twelve interrupt causes of an I2C bus controller into one raw status word, applies a software mask to it and drives a single registered interrupt line. Event logic elsewhere in the controller reports each cause on `src_in`. Ten of the causes arrive as one-cycle pulses and are held until software clears them. The receive-threshold and transmit-threshold causes are levels that simply follow the FIFO state.

Software clears sticky causes by reading. Every cause has its own read-to-clear address, and one further address clears all of them together. When a transfer is abandoned, the event logic pulses the reasons on `abort_in`. They are accumulated into an abort-reason vector, which is wiped by a read of the abort cause's clear address or of the combined clear address. Because each cause can be cleared separately, a handler can acknowledge exactly the causes it has read. A cause that fires between the status read and the clear read is therefore not lost.

Top module: `i2c_irq_stat`

## Requirements
- R1: After reset the raw status is 0 (apart from level causes whose input is high), the mask register is 0x254 (bits 2, 4, 6 and 9 set), the abort-reason vector is 0 and `irq` is low.
- R2: A read request (`req_valid`=1, `req_write`=0) returns `rd_data` with `rd_valid` high in the next cycle. The address map is: 0x00 raw status, 0x01 mask, 0x02 masked status, 0x03 abort-reason vector, 0x04 combined clear, and 0x10+i the clear for cause i. A per-cause clear read returns the cause's state before the clear in bit 0. The combined clear read returns the whole raw status before the clear. Only the mask (bits 11:0) is writable, and writes to any other address have no effect.
- R3: The masked status read at 0x02 equals the raw status AND the mask.
- R4: Cause bit positions are: 0 receive underflow, 1 receive overflow, 2 receive threshold, 3 transmit overflow, 4 transmit threshold, 5 read request, 6 transfer abort, 7 receive done, 8 bus activity, 9 stop seen, 10 start seen, 11 general call. All causes except bits 2 and 4 are set by a one-cycle pulse on `src_in` and stay set until cleared.
- R5: Bits 2 and 4 show the value their `src_in` input had one cycle earlier, and their clear reads leave them unchanged.
- R6: A read of 0x10+i clears cause i only. All other causes keep their state.
- R7: A read of 0x04 clears every sticky cause and the abort-reason vector. Level causes are unaffected.
- R8: Abort-reason bits are: 0 seven-bit address NACK, 1 first ten-bit address byte NACK, 2 second ten-bit address byte NACK, 3 data NACK, 4 general call NACK, 5 read after general call, 7 start byte ACKed, 9 start byte with restart off, 10 ten-bit read with restart off, 11 controller disabled, 12 arbitration lost. A pulse on `abort_in` sets these bits and they stay set. Bits 6 and 8 never set. A read of 0x16 (the transfer-abort clear) clears the vector.
- R9: If a set pulse and a clear read hit the same bit in the same cycle, the bit ends up set. This holds for both causes and abort reasons.
- R10: `irq` is the OR of the masked status bits, delayed by one register stage after the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Register word address |
| req_wdata | input | DATA_W (32) | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DATA_W (32) | Read data |
| src_in | input | 12 | Cause inputs (pulses; levels on bits 2 and 4) |
| abort_in | input | 13 | Abort-reason set pulses |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sticky bit shows up in the raw status read on the next read request. It also changes `irq` two cycles after the fault, provided that bit is unmasked. A clear decoded at the wrong index shows up as a cause that survives its own clear, or as a neighbouring cause that vanishes. Both effects can be seen by reading the status right after the clear. A stale abort-reason vector is visible at 0x03 straight after a clear of the abort cause. A lost same-cycle set is visible in the raw read that follows.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NUM_SRC   = 12;
  localparam int ABORT_W   = 13;
  // causes that follow a level and are never latched
  localparam logic [NUM_SRC-1:0] LEVEL_MAP = 12'h014;
  localparam logic [NUM_SRC-1:0] MASK_RESET = 12'h254;
  // abort-reason positions that exist (6 and 8 are holes)
  localparam logic [ABORT_W-1:0] ABORT_DEFINED = 13'h1EBF;
  localparam int SRC_TX_ABORT = 6;
  // register word addresses
  localparam int A_RAW     = 0;
  localparam int A_MASK    = 1;
  localparam int A_MSTAT   = 2;
  localparam int A_ABORT   = 3;
  localparam int A_CLR_ALL = 4;
  localparam int A_CLR_BASE = 16;
endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
  parameter int N = 12,
  parameter logic [N-1:0] LEVEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] raw_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    // a set in the same cycle as a clear wins
    always_comb begin
      if (LEVEL[i]) bit_d = src_in[i];
      else          bit_d = src_in[i] | (bit_q & ~clr_vec[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else     bit_q <= bit_d;
    end
    assign raw_q[i] = bit_q;
  end
endmodule

// File: rtl/abort_reason_latch.sv
module abort_reason_latch #(
  parameter int W = 13,
  parameter logic [W-1:0] DEFINED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_in,
  input  logic         clr,
  output logic [W-1:0] reason_q
);
  logic [W-1:0] keep;
  assign keep = clr ? '0 : reason_q;

  always_ff @(posedge clk) begin
    if (rst) reason_q <= '0;
    else     reason_q <= (set_in & DEFINED) | keep;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int N = NUM_SRC,
  parameter int W = ABORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [N-1:0]      raw,
  input  logic [N-1:0]      masked,
  input  logic [W-1:0]      reason,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      clr_vec,
  output logic              reason_clr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic rd_fire, wr_fire, clr_all;
  logic [DATA_W-1:0] rd_next;

  assign rd_fire = req_valid & ~req_write;
  assign wr_fire = req_valid &  req_write;
  assign clr_all = rd_fire && (req_addr == ADDR_W'(A_CLR_ALL));

  for (genvar i = 0; i < N; i++) begin : g_clr
    assign clr_vec[i] = clr_all ||
                        (rd_fire && (req_addr == ADDR_W'(A_CLR_BASE + i)));
  end
  assign reason_clr = clr_vec[SRC_TX_ABORT];

  always_ff @(posedge clk) begin
    if (rst) mask_q <= MASK_RESET;
    else if (wr_fire && (req_addr == ADDR_W'(A_MASK))) mask_q <= req_wdata[N-1:0];
  end

  always_comb begin
    rd_next = '0;
    if      (req_addr == ADDR_W'(A_RAW))     rd_next = DATA_W'(raw);
    else if (req_addr == ADDR_W'(A_MASK))    rd_next = DATA_W'(mask_q);
    else if (req_addr == ADDR_W'(A_MSTAT))   rd_next = DATA_W'(masked);
    else if (req_addr == ADDR_W'(A_ABORT))   rd_next = DATA_W'(reason);
    else if (req_addr == ADDR_W'(A_CLR_ALL)) rd_next = DATA_W'(raw);
    else begin
      for (int i = 0; i < N; i++)
        if (req_addr == ADDR_W'(A_CLR_BASE + i)) rd_next = DATA_W'(raw[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq_q
);
  assign masked = raw & mask;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/i2c_irq_stat.sv
module i2c_irq_stat
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ABORT_W-1:0] abort_in,
  output logic              irq
);
  logic [NUM_SRC-1:0] raw_q, mask_q, masked, clr_vec;
  logic [ABORT_W-1:0] abort_q;
  logic               reason_clr;

  irq_raw_bank #(.N(NUM_SRC), .LEVEL(LEVEL_MAP)) u_bank (
    .clk(clk), .rst(rst), .src_in(src_in), .clr_vec(clr_vec), .raw_q(raw_q)
  );

  abort_reason_latch #(.W(ABORT_W), .DEFINED(ABORT_DEFINED)) u_abort (
    .clk(clk), .rst(rst), .set_in(abort_in), .clr(reason_clr), .reason_q(abort_q)
  );

  irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NUM_SRC), .W(ABORT_W)) u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .raw(raw_q), .masked(masked), .reason(abort_q),
    .mask_q(mask_q), .clr_vec(clr_vec), .reason_clr(reason_clr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  irq_line_reg #(.N(NUM_SRC)) u_line (
    .clk(clk), .rst(rst), .raw(raw_q), .mask(mask_q),
    .masked(masked), .irq_q(irq)
  );
endmodule

// File: rtl/i2c_irq_stat_chk.sv
module i2c_irq_stat_chk
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [NUM_SRC-1:0] src_in,
  input logic [ABORT_W-1:0] abort_in,
  input logic              rd_valid,
  input logic              irq,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [ABORT_W-1:0] abort_q
);
  logic rd, clr_all, abort_clr;
  assign rd        = req_valid && !req_write;
  assign clr_all   = rd && (req_addr == ADDR_W'(A_CLR_ALL));
  assign abort_clr = clr_all || (rd && (req_addr == ADDR_W'(A_CLR_BASE + SRC_TX_ABORT)));

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd |=> rd_valid);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MAP[i]) begin : g_lvl
      a_r5_level_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> raw_q[i] == $past(src_in[i]));
    end else begin : g_stk
      a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        raw_q[i] && !clr_all && !(rd && req_addr == ADDR_W'(A_CLR_BASE + i)) |=> raw_q[i]);
      a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        src_in[i] |=> raw_q[i]);
    end
  end

  a_r8_abort_clear: assert property (@(posedge clk) disable iff (rst)
    abort_clr && (abort_in == '0) |=> abort_q == '0);

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(mask_q) == '0) |-> !irq);
endmodule

bind i2c_irq_stat i2c_irq_stat_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .src_in(src_in), .abort_in(abort_in),
  .rd_valid(rd_valid), .irq(irq), .raw_q(raw_q), .mask_q(mask_q),
  .abort_q(abort_q)
);

// File: tb/i2c_irq_stat_tb_top.sv
`timescale 1ns/1ps
module i2c_irq_stat_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [11:0] src_lvl = '0, src_pulse = '0;
  logic [11:0] src_in;
  logic [12:0] abort_in = '0;
  logic        irq;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  assign src_in = src_lvl | src_pulse;
  always #4 clk = ~clk;

  i2c_irq_stat dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .src_in(src_in), .abort_in(abort_in), .irq(irq)
  );

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] s, input logic [12:0] ab);
    @(negedge clk);
    src_pulse = s; abort_in = ab;
    @(negedge clk);
    src_pulse = '0; abort_in = '0;
  endtask

  // clear read and set pulse in the very same cycle
  task automatic read_with_pulse(input int a, input logic [11:0] s, input logic [12:0] ab,
                                 input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
    src_pulse = s; abort_in = ab;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0; src_pulse = '0; abort_in = '0;
  endtask

  task automatic check_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    bus_read(0, 32'h000, "R1 raw reset");
    bus_read(1, 32'h254, "R1 mask reset");
    bus_read(3, 32'h0000, "R1 abort reset");
    // R4 sticky cause, masked off: R3 masked view, R10 no irq
    pulse(12'h001, '0);
    bus_read(0, 32'h001, "R4 raw bit0 held");
    bus_read(2, 32'h000, "R3 masked with bit0 off");
    check_irq(1'b0, "R10 masked cause no irq");
    // abort cause with reasons; R8
    pulse(12'h040, 13'h1009);
    idle(2);
    check_irq(1'b1, "R10 irq on enabled cause");
    bus_read(0, 32'h041, "R4 raw bits 0 and 6");
    bus_read(2, 32'h040, "R3 masked abort");
    bus_read(3, 32'h1009, "R8 abort reasons latched");
    pulse('0, 13'h0140);
    bus_read(3, 32'h1009, "R8 holes 6 and 8 ignored");
    // R6 per-source clears
    bus_read(16, 32'h1, "R2 clear read returns prior bit0");
    bus_read(0, 32'h040, "R6 only bit0 cleared");
    bus_read(22, 32'h1, "R2 clear read returns prior bit6");
    bus_read(0, 32'h000, "R6 bit6 cleared");
    bus_read(3, 32'h0000, "R8 abort clear wipes reasons");
    idle(2);
    check_irq(1'b0, "R10 irq drops after clear");
    // R5 level cause
    @(negedge clk); src_lvl = 12'h004;
    idle(2);
    bus_read(0, 32'h004, "R5 level bit2 follows");
    check_irq(1'b1, "R10 level cause irq");
    bus_read(18, 32'h1, "R5 clear read of level bit");
    bus_read(0, 32'h004, "R5 level bit not cleared");
    @(negedge clk); src_lvl = 12'h000;
    idle(2);
    bus_read(0, 32'h000, "R5 level bit falls");
    // R9 set beats clear
    read_with_pulse(25, 12'h200, '0, 32'h0, "R9 clear read of unset bit9");
    bus_read(0, 32'h200, "R9 bit9 survives same-cycle clear");
    read_with_pulse(22, '0, 13'h0800, 32'h0, "R9 abort clear read");
    bus_read(3, 32'h0800, "R9 reason survives same-cycle clear");
    // R7 combined clear, with R6 isolation first
    pulse(12'hF0B, '0);
    @(negedge clk); src_lvl = 12'h010;
    idle(2);
    bus_read(0, 32'hF1B, "R4 many sticky bits");
    bus_read(17, 32'h1, "R6 clear bit1 read");
    bus_read(0, 32'hF19, "R6 neighbours kept");
    bus_read(4, 32'hF19, "R7 combined clear returns raw");
    bus_read(0, 32'h010, "R7 sticky cleared level kept");
    bus_read(3, 32'h0000, "R7 combined clear wipes reasons");
    @(negedge clk); src_lvl = 12'h000;
    idle(2);
    // R2 mask write, R10 irq follows mask
    bus_write(1, 32'hFFFF_F001);
    bus_read(1, 32'h001, "R2 mask write");
    pulse(12'h001, '0);
    idle(2);
    check_irq(1'b1, "R10 newly unmasked bit0");
    bus_read(2, 32'h001, "R3 masked bit0");
    bus_write(1, 32'h0);
    idle(2);
    check_irq(1'b0, "R10 mask zero");
    // R2 writes elsewhere ignored
    bus_write(0, 32'hFFF);
    bus_write(3, 32'h1FFF);
    bus_read(0, 32'h001, "R2 raw write ignored");
    bus_read(3, 32'h0000, "R2 abort write ignored");
    idle(3);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing reads: actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule